// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns bytes into asynchronous serial frames. Bytes are written into a small transmit queue. A framing engine takes them from the queue one at a time and shifts each one out on a single line. The line rests high. Each frame starts with a low start bit, followed by the data bits with the least significant bit first. An optional parity bit and one or two high stop bits close the frame. Bit timing comes from a clock-enable input that pulses at eight times the baud rate, so every bit lasts eight enable pulses.

A 6-bit control word sets the frame format. Its fields are the port enable, the data width (seven or eight bits), one or two stop bits, the parity enable and the parity mode (odd, even, forced zero or forced one). The frame engine latches the format when it takes a byte, so a later change to the control word never alters a frame that is already on the line.

Status outputs give the number of free queue entries, a busy flag for the frame engine and a sticky overflow flag. A synchronous queue-clear input empties the queue. A break input drives the line low while it is held.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` is 1, `tx_busy` is 0, `free_cnt` equals DEPTH (16) and `tx_ovf` is 0.
- R2: A frame is a low start bit, then the data bits LSB first, then the optional parity bit, then high stop bits. Every bit lasts OVERSAMPLE (8) cycles in which `tick_en` is high. The line is high between frames.
- R3: `ctrl[1]` = 1 selects 8 data bits and `ctrl[1]` = 0 selects 7 data bits. In 7-bit mode, bit 7 of the byte is not sent.
- R4: `ctrl[2]` = 1 sends two stop bits and `ctrl[2]` = 0 sends one.
- R5: `ctrl[3]` = 1 adds a parity bit after the data bits. Its value depends on `ctrl[5:4]`, computed over the data bits that are sent:
  - 0 makes the total count of ones odd.
  - 1 makes the total count of ones even.
  - 2 always sends 0.
  - 3 always sends 1.
- R6: `free_cnt` shows DEPTH minus the number of queued bytes, one cycle after each write or take. A value of 0 means the queue is full.
- R7: `tx_busy` is 1 from the cycle after a byte is taken until the cycle after its last stop bit ends. The `txd` output lags the internal line by one register stage.
- R8: A write while `free_cnt` is 0 is dropped and sets `tx_ovf`. `tx_ovf` stays set until reset or a queue clear.
- R9: While `ctrl[0]` is 0, no byte is taken from the queue and the line is held high. Clearing `ctrl[0]` during a frame abandons that frame.
- R10: `fifo_clr` empties the queue and clears `tx_ovf`. A write in the same cycle is dropped.
- R11: While `brk` is high, `txd` is 0 one cycle later. The frame engine keeps running underneath.
- R12: When a frame's last stop bit ends and the queue holds a byte, the next start bit begins on that same tick, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Enable pulse at eight times the baud rate |
| ctrl | input | 6 | Format: [0] enable, [1] 8-bit data, [2] two stop bits, [3] parity on, [5:4] parity mode |
| wr_en | input | 1 | Write `wr_data` into the queue |
| wr_data | input | DATA_W | Byte to queue |
| fifo_clr | input | 1 | Synchronous queue clear |
| brk | input | 1 | Force the line low |
| txd | output | 1 | Serial line (registered) |
| tx_busy | output | 1 | Frame in progress |
| free_cnt | output | $clog2(DEPTH+1) | Free queue entries |
| tx_ovf | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default parameters: DEPTH 16, OVERSAMPLE 8 and DATA_W 8. With these values the 5-bit free count, the full-queue overflow after seventeen writes and every frame length from nine to twelve bits can all be reached in a short run. A reference model built on queues follows each frame bit by bit, both with ticks on every cycle and with ticks every third cycle. It covers every parity mode in both data widths, back-to-back frames, an abort in the middle of a frame, a clear that coincides with a write, and a break laid over a running frame.

// File: rtl/uart_ftx_pkg.sv
package uart_ftx_pkg;

  localparam int CFG_W = 6;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ZERO  = 2'd2,
    PAR_ONE   = 2'd3
  } par_mode_e;

  // Field positions match the ctrl port: [5:4] mode, [3] parity on,
  // [2] two stop bits, [1] 8-bit data, [0] enable.
  typedef struct packed {
    par_mode_e par_mode;
    logic      par_on;
    logic      two_stop;
    logic      wide;
    logic      enable;
  } tx_cfg_t;

endpackage

// File: rtl/uart_ftx_fifo.sv
module uart_ftx_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic [CNT_W-1:0]  free,
  output logic              ovf
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  free_q;
  logic              ovf_q;
  logic              wr_ok, rd_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (free_q == CNT_W'(DEPTH));
  assign wr_ok = push && !clr && (free_q != '0);
  assign rd_ok = pop && !clr && !empty;

  // Storage without reset so it can map to distributed RAM.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      free_q   <= CNT_W'(DEPTH);
      ovf_q    <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (rd_ok) rd_ptr_q <= ptr_inc(rd_ptr_q);
      free_q <= free_q - CNT_W'(wr_ok) + CNT_W'(rd_ok);
      if (push && free_q == '0) ovf_q <= 1'b1;
    end
  end

  assign head = mem[rd_ptr_q];
  assign free = free_q;
  assign ovf  = ovf_q;

endmodule

// File: rtl/uart_ftx_framer.sv
module uart_ftx_framer
  import uart_ftx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 8,
  localparam int FRAME_W   = DATA_W + 4,
  localparam int LEN_W     = $clog2(FRAME_W + 1),
  localparam int TICK_W    = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  tx_cfg_t           cfg,
  input  logic              empty,
  input  logic [DATA_W-1:0] head,
  output logic              pop,
  output logic              line,
  output logic              busy
);

  logic               active_q, line_q;
  logic [TICK_W-1:0]  tick_q;
  logic [FRAME_W-1:0] sr_q;
  logic [LEN_W-1:0]   left_q;

  logic [FRAME_W-1:0] frm;
  logic [LEN_W-1:0]   frm_len;
  logic               xr, pbit;
  logic [LEN_W-1:0]   ndata;
  logic               bit_end, last_bit, start;

  // Build the whole frame at take time; unused upper positions stay high.
  always_comb begin
    ndata = cfg.wide ? LEN_W'(DATA_W) : LEN_W'(DATA_W - 1);
    xr    = 1'b0;
    frm   = '1;
    frm[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (LEN_W'(i) < ndata) begin
        frm[i + 1] = head[i];
        xr         = xr ^ head[i];
      end
    end
    unique case (cfg.par_mode)
      PAR_ODD:  pbit = ~xr;
      PAR_EVEN: pbit = xr;
      PAR_ZERO: pbit = 1'b0;
      default:  pbit = 1'b1;
    endcase
    for (int j = 1; j < FRAME_W; j++) begin
      if (cfg.par_on && LEN_W'(j) == ndata + 1'b1) frm[j] = pbit;
    end
    frm_len = ndata + LEN_W'(2) + LEN_W'(cfg.par_on) + LEN_W'(cfg.two_stop);
  end

  assign bit_end  = tick && active_q && (tick_q == TICK_W'(OVERSAMPLE - 1));
  assign last_bit = (left_q == '0);
  assign start    = cfg.enable && tick && !empty &&
                    (!active_q || (bit_end && last_bit));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      line_q   <= 1'b1;
      tick_q   <= '0;
      sr_q     <= '1;
      left_q   <= '0;
    end else if (!cfg.enable) begin
      active_q <= 1'b0;
      line_q   <= 1'b1;
      tick_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      line_q   <= frm[0];
      sr_q     <= frm >> 1;
      left_q   <= frm_len - 1'b1;
      tick_q   <= '0;
    end else if (tick && active_q) begin
      if (bit_end) begin
        tick_q <= '0;
        if (last_bit) begin
          active_q <= 1'b0;
          line_q   <= 1'b1;
        end else begin
          line_q <= sr_q[0];
          sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
          left_q <= left_q - 1'b1;
        end
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign pop  = start;
  assign line = line_q;
  assign busy = active_q;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_ftx_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 8,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [CFG_W-1:0]  ctrl,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fifo_clr,
  input  logic              brk,
  output logic              txd,
  output logic              tx_busy,
  output logic [CNT_W-1:0]  free_cnt,
  output logic              tx_ovf
);

  tx_cfg_t           cfg;
  logic [DATA_W-1:0] head;
  logic              empty, pop, line;
  logic              txd_q;

  assign cfg = tx_cfg_t'(ctrl);

  uart_ftx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) fifo_i (
    .clk(clk), .rst(rst), .clr(fifo_clr),
    .push(wr_en), .push_data(wr_data), .pop(pop),
    .head(head), .empty(empty), .free(free_cnt), .ovf(tx_ovf)
  );

  uart_ftx_framer #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) framer_i (
    .clk(clk), .rst(rst), .tick(tick_en), .cfg(cfg),
    .empty(empty), .head(head), .pop(pop), .line(line), .busy(tx_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) txd_q <= 1'b1;
    else     txd_q <= line & ~brk;
  end

  assign txd = txd_q;

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             wr_en,
  input logic             fifo_clr,
  input logic             brk,
  input logic             txd,
  input logic             tx_busy,
  input logic [CNT_W-1:0] free_cnt,
  input logic             tx_ovf
);

  AST_FREE_RANGE: assert property (@(posedge clk) disable iff (rst)
    free_cnt <= CNT_W'(DEPTH)); // R6

  AST_FULL_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !fifo_clr && free_cnt == '0) |=> tx_ovf); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tx_ovf && !fifo_clr) |=> tx_ovf); // R8

  AST_NO_TAKE_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr_en && !fifo_clr) |=> $stable(free_cnt)); // R9

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    brk |=> !txd); // R11

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |=> !txd); // R2

endmodule

bind uart_frame_tx uart_frame_tx_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .en(ctrl[0]), .wr_en(wr_en), .fifo_clr(fifo_clr),
  .brk(brk), .txd(txd), .tx_busy(tx_busy), .free_cnt(free_cnt), .tx_ovf(tx_ovf)
);

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;

  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int OS    = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic [5:0] ctrl = 6'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       fifo_clr = 1'b0;
  logic       brk = 1'b0;
  logic       txd, tx_busy, tx_ovf;
  logic [4:0] free_cnt;

  int total = 0;
  int bad = 0;
  int tick_div = 1;
  int tick_cnt = 0;
  bit started = 0;
  bit done = 0;
  string cur = "R1";

  always #5 clk = ~clk;

  uart_frame_tx #(.DEPTH(DEPTH), .DATA_W(DW), .OVERSAMPLE(OS)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ctrl(ctrl), .wr_en(wr_en),
    .wr_data(wr_data), .fifo_clr(fifo_clr), .brk(brk), .txd(txd),
    .tx_busy(tx_busy), .free_cnt(free_cnt), .tx_ovf(tx_ovf)
  );

  // Reference model
  int  q[$];
  bit  m_active, m_line = 1, m_txd = 1, m_ovf;
  int  m_tick, m_idx, m_len;
  bit  m_bits[12];

  task automatic load_frame(input int d);
    int nd, pos, ones;
    bit p;
    nd = ctrl[1] ? 8 : 7;
    m_bits[0] = 0;
    ones = 0;
    for (int i = 0; i < nd; i++) begin
      m_bits[1 + i] = d[i];
      ones += d[i];
    end
    pos = 1 + nd;
    if (ctrl[3]) begin
      case (ctrl[5:4])
        2'd0: p = (ones % 2 == 0);
        2'd1: p = (ones % 2 == 1);
        2'd2: p = 0;
        default: p = 1;
      endcase
      m_bits[pos] = p;
      pos++;
    end
    m_bits[pos] = 1; pos++;
    if (ctrl[2]) begin m_bits[pos] = 1; pos++; end
    m_len = pos; m_idx = 0; m_tick = 0; m_active = 1; m_line = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_active = 0; m_line = 1; m_txd = 1; m_ovf = 0; m_tick = 0;
      started = 1;
    end else begin
      int sz;
      bit st, old_line;
      sz = q.size(); st = 0; old_line = m_line;
      if (!ctrl[0]) begin
        m_active = 0; m_line = 1; m_tick = 0;
      end else if (tick_en) begin
        if (m_active) begin
          if (m_tick == OS - 1) begin
            m_tick = 0;
            if (m_idx == m_len - 1) begin
              if (sz > 0) st = 1;
              else begin m_active = 0; m_line = 1; end
            end else begin
              m_idx++; m_line = m_bits[m_idx];
            end
          end else m_tick++;
        end else if (sz > 0) st = 1;
      end
      if (st) begin load_frame(q[0]); void'(q.pop_front()); end
      if (fifo_clr) begin q.delete(); m_ovf = 0; end
      else if (wr_en) begin
        if (sz < DEPTH) q.push_back(int'(wr_data)); else m_ovf = 1;
      end
      m_txd = old_line & ~brk;
    end
  end

  task automatic cmp(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s (during %s): actual=%0d expected=%0d", tag, what, cur, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst && !done) begin
      cmp("R2", int'(txd), int'(m_txd), "txd");
      cmp("R7", int'(tx_busy), int'(m_active), "tx_busy");
      cmp("R6", int'(free_cnt), DEPTH - q.size(), "free_cnt");
      cmp("R8", int'(tx_ovf), int'(m_ovf), "tx_ovf");
    end
  end

  // Tick generator
  always @(negedge clk) begin
    #1;
    tick_cnt++;
    tick_en = (tick_cnt % tick_div == 0);
  end

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic put(input int d);
    step(); wr_en = 1; wr_data = 8'(d);
    step(); wr_en = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 8000; i++) begin
      if (!m_active && q.size() == 0) break;
      step();
    end
    repeat (3) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 0;
    step();
    cur = "R1";
    cmp("R1", int'(txd), 1, "reset txd");
    cmp("R1", int'(tx_busy), 0, "reset busy");
    cmp("R1", int'(free_cnt), 16, "reset free");
    cmp("R1", int'(tx_ovf), 0, "reset ovf");

    // R2 / R12: 8N1, slow ticks, back-to-back frames
    cur = "R2"; tick_div = 3; ctrl = 6'b000011;
    step(); wr_en = 1; wr_data = 8'hA5;
    step(); wr_data = 8'h3C;
    step(); wr_data = 8'hFF;
    step(); wr_en = 0;
    cur = "R12"; drain();

    // R3: 7-bit data, bit 7 dropped
    cur = "R3"; tick_div = 1; ctrl = 6'b000001;
    put(8'h80); put(8'h55); drain();

    // R4: two stop bits
    cur = "R4"; ctrl = 6'b000111;
    put(8'h0F); put(8'hF0); drain();

    // R5: every parity mode in both widths
    cur = "R5";
    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < 2; w++) begin
        ctrl = {2'(m), 1'b1, 1'b0, 1'(w), 1'b1};
        put(8'h01); put(8'h83); drain();
      end
    end

    // R8 / R9: queue filled while disabled, then overflow
    cur = "R8"; ctrl = 6'b000010;
    step(); wr_en = 1;
    for (int i = 0; i < 17; i++) begin wr_data = 8'(i * 13 + 1); step(); end
    wr_en = 0; step();
    cmp("R8", int'(free_cnt), 0, "free after fill");
    cmp("R8", int'(tx_ovf), 1, "ovf after 17 writes");
    cur = "R9";
    repeat (60) step();
    cmp("R9", int'(free_cnt), 0, "no take while disabled");
    cmp("R9", int'(txd), 1, "idle line while disabled");

    // enable, send a few frames, then abort mid-frame
    ctrl = 6'b000011;
    repeat (200) step();
    while (!m_active) step();
    repeat (20) step();
    ctrl = 6'b000010;
    step(); step();
    cmp("R9", int'(tx_busy), 0, "abort clears busy");
    cmp("R9", int'(txd), 1, "abort returns line high");

    // R10: clear with a coincident write
    cur = "R10";
    step(); fifo_clr = 1; wr_en = 1; wr_data = 8'h77;
    step(); fifo_clr = 0; wr_en = 0;
    cmp("R10", int'(free_cnt), 16, "free after clear");
    cmp("R10", int'(tx_ovf), 0, "ovf after clear");

    // R11: break over a running frame
    cur = "R11"; ctrl = 6'b000011;
    put(8'hFF); put(8'hFE);
    repeat (10) step();
    brk = 1;
    step(); step();
    cmp("R11", int'(txd), 0, "break holds low");
    repeat (30) step();
    cmp("R11", int'(txd), 0, "break still low");
    brk = 0;
    drain();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule